// File: doc/BRIEF.md
# Grouped Memory-Select Test Controller

This block sits between a memory-test engine and a bank of small RAMs arranged as groups of slices. Software or a test host programs two registers over a simple register bus. The chip-select register says which slices to enable. The RAM configuration register names one group and one return slice. The controller raises the chip selects of the enabled slices in the named group whenever the engine issues a read or write command. It hands back the read data of exactly one RAM.

Several slices can be driven together, which lets one write stimulate many RAMs. Observation always stays on a single RAM. If the named return slice is not enabled, or the named group does not exist, the returned data is forced to zero. A read issued in that state also sets a sticky status flag. A write to a decode address loads the chip-select register with the one-hot image of the return-slice number, which is the usual single-RAM setting.

Top module: `mgs_ctrl_top`

## Requirements
- R1: After reset, the chip-select register reads 0, the status flag reads 0, `slice_miss` is 0, no `ram_cs` bit is high and `bus_rvalid` is 0.
- R2: A `ram_cs` bit is high only while `cmd_valid` is 1 and the matching chip-select register bit is 1. With `cmd_valid` 0, every `ram_cs` bit is 0.
- R3: The group number is taken from RAM configuration bits [31:24]. Only the `ram_cs` lanes of that group (bits g*NUM_SLICES upward) may be high. A group number of NUM_GROUPS or more drives no chip select and returns zero data.
- R4: With several chip-select bits set, all matching RAMs of the group are selected together, while `ret_data` still comes from the one return slice.
- R5: The return slice number is taken from RAM configuration bits [20:16], within the return field [23:16]. When that slice's chip-select bit is 1 and the group exists, `ret_data` equals that RAM's lane of `ram_rdata` (lane index group*NUM_SLICES+slice, DATA_W bits each).
- R6: When the return slice is not enabled or the group does not exist, `ret_data` is 0. A read command (`cmd_valid`=1, `cmd_write`=0) in that state sets the sticky status flag, while a write command does not. Writing 1 to bit 0 of the status address (2) clears the flag, and a set in the same cycle wins over the clear.
- R7: Any bus write to the decode address (3) loads the chip-select register with a single 1 at the position given by configuration bits [20:16].
- R8: Register bus writes take effect at the clock edge that accepts them. A read returns data with `bus_rvalid` one cycle later. Address 0 is the chip-select register, address 1 is the full 32-bit RAM configuration register, address 2 has the status flag in bit 0, and address 3 reads as zero.
- R9: `ram_we` is 1 exactly while `cmd_valid` and `cmd_write` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data |
| cmd_valid | input | 1 | Engine command in progress |
| cmd_write | input | 1 | Command is a write (1) or read (0) |
| ram_cs | output | NUM_GROUPS*NUM_SLICES | Per-RAM chip selects, group-major |
| ram_we | output | 1 | Shared write enable |
| ram_rdata | input | NUM_GROUPS*NUM_SLICES*DATA_W | Read data of every RAM, group-major lanes |
| ret_data | output | DATA_W | Data of the selected return RAM |
| slice_miss | output | 1 | Sticky flag: read issued on a disabled return slice |

## Verification
The assertions assume that `cmd_valid`, `cmd_write` and the bus inputs are driven to known values in every cycle after reset. They also assume the RAM configuration register is written before any command relies on it, because it has no reset value. The stimulus meets these assumptions by holding every input at zero through reset. It then programs the configuration register before the first command, and it changes inputs only just after a rising edge, so each value stays stable for a whole cycle.

// File: rtl/mgs_pkg.sv
// Package: shared constants and register address codes for the grouped
// memory-select controller. Assumes a 32-bit register bus.
package mgs_pkg;
    localparam int REG_W     = 32;
    localparam int GRP_LSB   = 24;
    localparam int GRP_W     = 8;
    localparam int RET_LSB   = 16;
    localparam int RET_W     = 8;

    typedef enum logic [1:0] {
        ADR_CHIPSEL = 2'd0,
        ADR_RAMCFG  = 2'd1,
        ADR_STATUS  = 2'd2,
        ADR_DECODE  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/mgs_regfile.sv
// Register file: chip-select register, RAM configuration register (no
// reset), sticky miss status and the one-cycle read path.
// Assumes NUM_SLICES <= 32 and a set request that overrides a clear.
module mgs_regfile #(
    parameter int NUM_SLICES = 32,
    localparam int SLICE_W   = $clog2(NUM_SLICES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic [1:0]              bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic                    bus_rvalid,
    output logic [31:0]             bus_rdata,
    input  logic                    miss_set,
    output logic [NUM_SLICES-1:0]   cs_reg,
    output logic [31:0]             cfg_reg,
    output logic                    miss_flag
);
    import mgs_pkg::*;

    logic wr_en;
    logic rd_en;
    logic [SLICE_W-1:0] dec_idx;
    logic [31:0] rd_mux;

    // Decode bus strobes and the slice number used by the decode helper.
    always_comb begin
        wr_en   = bus_valid && bus_write;
        rd_en   = bus_valid && !bus_write;
        dec_idx = cfg_reg[RET_LSB +: SLICE_W];
    end

    // Chip-select register: direct write or one-hot load from return slice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_reg <= '0;
        end else if (wr_en && bus_addr == ADR_CHIPSEL) begin
            cs_reg <= bus_wdata[NUM_SLICES-1:0];
        end else if (wr_en && bus_addr == ADR_DECODE) begin
            cs_reg <= NUM_SLICES'(1) << dec_idx;
        end
    end

    // RAM configuration register: deliberately left without reset.
    always_ff @(posedge clk) begin
        if (wr_en && bus_addr == ADR_RAMCFG) begin
            cfg_reg <= bus_wdata;
        end
    end

    // Sticky miss flag: a set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_flag <= 1'b0;
        end else if (miss_set) begin
            miss_flag <= 1'b1;
        end else if (wr_en && bus_addr == ADR_STATUS && bus_wdata[0]) begin
            miss_flag <= 1'b0;
        end
    end

    // Select the register addressed by a read.
    always_comb begin
        case (bus_addr)
            ADR_CHIPSEL: rd_mux = 32'(cs_reg);
            ADR_RAMCFG:  rd_mux = cfg_reg;
            ADR_STATUS:  rd_mux = {31'd0, miss_flag};
            default:     rd_mux = 32'd0;
        endcase
    end

    // Return read data one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd_en;
            if (rd_en) begin
                bus_rdata <= rd_mux;
            end
        end
    end

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> bus_rvalid);                                              // R8
    AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !bus_rvalid);                                            // R8
    AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == ADR_DECODE) |=> $onehot(cs_reg));             // R7
    AST_MISS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_flag && !(wr_en && bus_addr == ADR_STATUS && bus_wdata[0]))
            |=> miss_flag);                                                 // R6
endmodule

// File: rtl/mgs_cs_gate.sv
// Chip-select gating: one lane block per group; a group's lanes follow the
// chip-select register only while a command runs and the group is named.
// Assumes group-major packing of the chip-select outputs.
module mgs_cs_gate #(
    parameter int NUM_GROUPS = 4,
    parameter int NUM_SLICES = 32,
    parameter int GRP_W      = 8,
    localparam int NUM_RAMS  = NUM_GROUPS * NUM_SLICES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic                  cmd_write,
    input  logic [GRP_W-1:0]      grp_sel,
    input  logic [NUM_SLICES-1:0] cs_reg,
    output logic [NUM_RAMS-1:0]   ram_cs,
    output logic                  ram_we
);
    logic [NUM_GROUPS-1:0] grp_active;

    // Per-group qualification of the chip-select vector.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        always_comb begin
            ram_cs[g*NUM_SLICES +: NUM_SLICES] =
                (cmd_valid && grp_sel == GRP_W'(g)) ? cs_reg : '0;
            grp_active[g] = |ram_cs[g*NUM_SLICES +: NUM_SLICES];
        end
    end

    // Shared write strobe for all selected RAMs.
    always_comb begin
        ram_we = cmd_valid && cmd_write;
    end

    AST_CS_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (|ram_cs) |-> cmd_valid);                                           // R2
    AST_ONE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grp_active));                                              // R3
    AST_WE_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> cmd_valid);                                              // R9
endmodule

// File: rtl/mgs_ret_mux.sv
// Return-data multiplexer: picks one RAM lane by group and slice, zeroes
// the result when that slice is disabled or the group is absent, and
// reports a miss for read commands. Assumes group-major read-data lanes.
module mgs_ret_mux #(
    parameter int NUM_GROUPS = 4,
    parameter int NUM_SLICES = 32,
    parameter int DATA_W     = 32,
    parameter int GRP_W      = 8,
    localparam int SLICE_W   = $clog2(NUM_SLICES),
    localparam int NUM_RAMS  = NUM_GROUPS * NUM_SLICES,
    localparam int IDX_W     = $clog2(NUM_RAMS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    input  logic                       cmd_write,
    input  logic [GRP_W-1:0]           grp_sel,
    input  logic [SLICE_W-1:0]         slice_sel,
    input  logic [NUM_SLICES-1:0]      cs_reg,
    input  logic [NUM_RAMS*DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0]          ret_data,
    output logic                       miss_set
);
    logic [DATA_W-1:0] lane [NUM_RAMS];
    logic              grp_ok;
    logic              slice_on;
    logic [IDX_W-1:0]  lane_idx;

    // Unpack the flat read-data bus into lanes.
    for (genvar r = 0; r < NUM_RAMS; r++) begin : g_lane
        assign lane[r] = ram_rdata[r*DATA_W +: DATA_W];
    end

    // Validate group and slice and form the lane index.
    always_comb begin
        grp_ok   = 32'(grp_sel) < NUM_GROUPS;
        slice_on = cs_reg[slice_sel];
        lane_idx = grp_ok ? IDX_W'(32'(grp_sel) * NUM_SLICES + 32'(slice_sel))
                          : '0;
    end

    // Drive returned data, forced to zero on a miss.
    always_comb begin
        ret_data = (grp_ok && slice_on) ? lane[lane_idx] : '0;
    end

    // A read command on a missing slice requests the sticky flag.
    always_comb begin
        miss_set = cmd_valid && !cmd_write && !(grp_ok && slice_on);
    end

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        miss_set |-> (ret_data == '0));                                     // R6
    AST_SET_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        miss_set |-> (cmd_valid && !cmd_write));                            // R6
endmodule

// File: rtl/mgs_ctrl_top.sv
// Top: grouped memory-select test controller. Connects the register file,
// chip-select gating and return-data multiplexer. Assumes NUM_SLICES <= 32
// and NUM_GROUPS <= 256 (8-bit group field).
module mgs_ctrl_top #(
    parameter int NUM_GROUPS = 4,
    parameter int NUM_SLICES = 32,
    parameter int DATA_W     = 32,
    localparam int SLICE_W   = $clog2(NUM_SLICES),
    localparam int NUM_RAMS  = NUM_GROUPS * NUM_SLICES
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_valid,
    input  logic                       bus_write,
    input  logic [1:0]                 bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic                       bus_rvalid,
    output logic [31:0]                bus_rdata,
    input  logic                       cmd_valid,
    input  logic                       cmd_write,
    output logic [NUM_RAMS-1:0]        ram_cs,
    output logic                       ram_we,
    input  logic [NUM_RAMS*DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0]          ret_data,
    output logic                       slice_miss
);
    import mgs_pkg::*;

    logic [NUM_SLICES-1:0] cs_reg;
    logic [31:0]           cfg_reg;
    logic                  miss_set;
    logic [GRP_W-1:0]      grp_sel;
    logic [SLICE_W-1:0]    slice_sel;

    // Extract the group and return-slice fields from the configuration.
    always_comb begin
        grp_sel   = cfg_reg[GRP_LSB +: GRP_W];
        slice_sel = cfg_reg[RET_LSB +: SLICE_W];
    end

    mgs_regfile #(.NUM_SLICES(NUM_SLICES)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .miss_set(miss_set), .cs_reg(cs_reg), .cfg_reg(cfg_reg),
        .miss_flag(slice_miss)
    );

    mgs_cs_gate #(.NUM_GROUPS(NUM_GROUPS), .NUM_SLICES(NUM_SLICES),
                  .GRP_W(GRP_W)) u_gate (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .grp_sel(grp_sel),
        .cs_reg(cs_reg), .ram_cs(ram_cs), .ram_we(ram_we)
    );

    mgs_ret_mux #(.NUM_GROUPS(NUM_GROUPS), .NUM_SLICES(NUM_SLICES),
                  .DATA_W(DATA_W), .GRP_W(GRP_W)) u_ret (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .grp_sel(grp_sel), .slice_sel(slice_sel), .cs_reg(cs_reg),
        .ram_rdata(ram_rdata), .ret_data(ret_data), .miss_set(miss_set)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (slice_miss == 1'b0 && bus_rvalid == 1'b0));             // R1
endmodule

// File: tb/mgs_ctrl_top_bench.sv
// Scoreboard bench: driver tasks push expected items tagged with the cycle
// they fall due; a monitor at the falling edge pops and compares them.
module mgs_ctrl_top_bench;
    localparam int NG = 4;
    localparam int NS = 32;
    localparam int DW = 32;
    localparam int NR = NG * NS;

    localparam int K_RET = 0, K_RD = 1, K_CS = 2, K_MISS = 3, K_WE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic bus_rvalid;
    logic [31:0] bus_rdata;
    logic cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [NR-1:0] ram_cs;
    logic ram_we;
    logic [NR*DW-1:0] ram_rdata;
    logic [DW-1:0] ret_data;
    logic slice_miss;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;

    int            q_due[$];
    int            q_kind[$];
    logic [127:0]  q_exp[$];
    string         q_req[$];

    // Bench model of the programmed state.
    logic [31:0] cs_m = 32'd0;
    logic [31:0] cfg_m = 32'd0;
    logic        miss_m = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    mgs_ctrl_top u_mgs_ctrl_top (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .ram_cs(ram_cs), .ram_we(ram_we), .ram_rdata(ram_rdata),
        .ret_data(ret_data), .slice_miss(slice_miss)
    );

    function automatic logic [31:0] pat(int i);
        return 32'h5A00_0000 + 32'(i) * 32'h0001_0003;
    endfunction

    function automatic logic [127:0] observe(int kind);
        case (kind)
            K_RET:  return 128'(ret_data);
            K_RD:   return bus_rvalid ? 128'(bus_rdata) : {128{1'b1}};
            K_CS:   return 128'(ram_cs);
            K_MISS: return 128'(slice_miss);
            default: return 128'(ram_we);
        endcase
    endfunction

    function automatic logic exp_hit();
        return (int'(cfg_m[31:24]) < NG) && cs_m[cfg_m[20:16]];
    endfunction

    function automatic logic [127:0] exp_ret();
        return exp_hit() ? 128'(pat(int'(cfg_m[31:24]) * NS + int'(cfg_m[20:16]))) : 128'd0;
    endfunction

    function automatic logic [127:0] exp_cs(logic v);
        if (!v || int'(cfg_m[31:24]) >= NG) return 128'd0;
        return 128'(cs_m) << (int'(cfg_m[31:24]) * NS);
    endfunction

    task automatic push(int due, int kind, logic [127:0] e, string req);
        q_due.push_back(due); q_kind.push_back(kind);
        q_exp.push_back(e);   q_req.push_back(req);
    endtask

    // Monitor: compare every item due in this cycle.
    always @(negedge clk) begin
        for (int i = q_due.size() - 1; i >= 0; i--) begin
            if (q_due[i] <= cyc) begin
                logic [127:0] got;
                got = observe(q_kind[i]);
                n_cmp++;
                if (q_due[i] != cyc || got !== q_exp[i]) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h",
                             q_req[i], q_kind[i], got, q_exp[i]);
                end
                q_due.delete(i); q_kind.delete(i);
                q_exp.delete(i); q_req.delete(i);
            end
        end
    end

    task automatic bus_wr(logic [1:0] a, logic [31:0] d);
        @(posedge clk); #1;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        case (a)
            2'd0: cs_m = d;
            2'd1: cfg_m = d;
            2'd2: if (d[0]) miss_m = 1'b0;
            default: cs_m = 32'd1 << d[4:0] * 0 << cfg_m[20:16];
        endcase
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(logic [1:0] a, string req);
        logic [31:0] e;
        case (a)
            2'd0: e = cs_m;
            2'd1: e = cfg_m;
            2'd2: e = {31'd0, miss_m};
            default: e = 32'd0;
        endcase
        @(posedge clk); #1;
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        push(cyc + 1, K_RD, 128'(e), req);
        @(posedge clk); #1;
        bus_valid = 1'b0;
    endtask

    // Engine command, optionally with a same-cycle status clear write.
    task automatic cmd(logic v, logic w, logic clr, string req);
        logic setc;
        @(posedge clk); #1;
        cmd_valid = v; cmd_write = w;
        if (clr) begin
            bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 2'd2; bus_wdata = 32'd1;
        end
        push(cyc, K_CS, exp_cs(v), req);
        push(cyc, K_RET, exp_ret(), req);
        push(cyc, K_WE, 128'(v && w), req);
        setc = v && !w && !exp_hit();
        if (clr && !setc) miss_m = 1'b0;
        if (setc) miss_m = 1'b1;
        push(cyc + 1, K_MISS, 128'(miss_m), req);
        @(posedge clk); #1;
        cmd_valid = 1'b0; cmd_write = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NR; i++) ram_rdata[i*DW +: DW] = pat(i);
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        push(cyc, K_CS, 128'd0, "R1 no cs after reset");
        push(cyc, K_MISS, 128'd0, "R1 miss clear after reset");
        push(cyc, K_RD, {128{1'b1}}, "R1 rvalid low after reset");
        bus_rd(2'd0, "R1 chip-select reg zero");
        bus_rd(2'd2, "R1 status zero");
        // R8: configuration readback, group 1 slice 5
        bus_wr(2'd1, 32'h0105_A5C3);
        bus_rd(2'd1, "R8 config readback");
        bus_rd(2'd3, "R8 decode address reads zero");
        // R7: decode helper
        bus_wr(2'd3, 32'h0);
        bus_rd(2'd0, "R7 decode loads one-hot");
        cmd(1'b1, 1'b0, 1'b0, "R5 read selects slice");
        cmd(1'b0, 1'b0, 1'b0, "R2 idle no cs");
        // R4, R9: multiple slices written together
        bus_wr(2'd0, 32'h0000_0121);
        cmd(1'b1, 1'b1, 1'b0, "R4 R9 multi-slice write");
        cmd(1'b1, 1'b0, 1'b0, "R4 multi-slice read one return");
        // R3, R5: group 3 slice 8
        bus_wr(2'd1, 32'h0308_0000);
        cmd(1'b1, 1'b0, 1'b0, "R3 R5 group 3 slice 8");
        // R3, R6: absent group
        bus_wr(2'd1, 32'h0700_0000);
        cmd(1'b1, 1'b1, 1'b0, "R3 absent group write no miss");
        cmd(1'b1, 1'b0, 1'b0, "R3 R6 absent group read miss");
        bus_rd(2'd2, "R6 status set");
        bus_wr(2'd2, 32'h1);
        bus_rd(2'd2, "R6 status cleared");
        // R6: disabled slice 2 in group 0
        bus_wr(2'd1, 32'h0002_0000);
        cmd(1'b1, 1'b1, 1'b0, "R6 write on disabled slice no miss");
        cmd(1'b1, 1'b0, 1'b0, "R6 read on disabled slice miss");
        cmd(1'b1, 1'b0, 1'b1, "R6 set wins over clear");
        bus_rd(2'd2, "R6 status after set-wins");
        // R6: clear while hit, group 0 slice 0
        bus_wr(2'd1, 32'h0000_0000);
        cmd(1'b1, 1'b0, 1'b1, "R6 clear with hit read");
        bus_rd(2'd2, "R6 status after clear");
        repeat (3) @(posedge clk);
        if (q_due.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", q_due.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule